// File: doc/BRIEF.md
# Delegated Interrupt Register View

This block keeps the machine-level interrupt state of a processor hart: a pending vector, an enable vector and a delegation mask. Software reads and writes them through a single CSR access port. A 3-bit selector picks one of five views. Three of these views are the stored registers. The other two are supervisor views that are computed from the stored state and never held in flops of their own.

The supervisor views are filtered by delegation. On a read, a pending machine interrupt whose delegation bit is set shows up at the position of the matching supervisor interrupt. On a write, the supervisor enable view only reaches the bits whose delegation is set, and the supervisor pending view only reaches the supervisor software bit.

Hardware interrupt sources for the machine external, timer and software lines, and for the supervisor external line, are registered once and ORed into the pending vector. Software cannot raise or drop these lines.

Top module: `irq_csr_view`

## Requirements
- R1: Interrupt bit positions are: machine external 11, supervisor external 9, user external 8, machine timer 7, supervisor timer 5, user timer 4, machine software 3, supervisor software 1, user software 0. A write with selector 0 (pending register) changes only the software-held bits 9, 5 and 1. Every other pending bit keeps its value.
- R2: A write with selector 1 (enable register) loads bits 11, 9, 7, 5, 3 and 1 from the write value. The user bits 8, 4 and 0 keep their value.
- R3: A write with selector 2 (delegation mask) stores the whole XLEN-bit write value, and reading selector 2 returns it unchanged.
- R4: A read with selector 3 (supervisor pending view) returns these values. Bit 9 is (p9&d9)|(p11&d11). Bit 5 is (p5&d5)|(p7&d7). Bit 1 is (p1&d1)|(p3&d3). Each user bit is p&d. All other bits are 0. Here p is the pending register and d is the delegation mask.
- R5: A read with selector 4 (supervisor enable view) returns enable&delegation at bits 9, 8, 5, 4, 1 and 0. All other bits read as zero, even when the machine enables and their delegation bits are set.
- R6: A write with selector 3 changes only pending bit 1, which becomes write bit 1 AND delegation bit 1.
- R7: A write with selector 4 loads each of the enable bits 9, 8, 5, 4, 1 and 0 whose delegation bit is set. Bits that are not delegated keep their value.
- R8: The hardware inputs for machine external, machine timer, machine software and supervisor external are sampled on each clock edge. They appear in the pending register after that edge. Software writes cannot set or clear the three machine pending bits.
- R9: Reset clears the pending, enable and delegation state. Every view then reads zero.
- R10: Read data follows the selector and the current state combinationally. Selector codes 5 to 7 read zero, and writes with those codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the selected view |
| csr_sel | input | 3 | View selector: 0 pending, 1 enable, 2 delegation, 3 supervisor pending, 4 supervisor enable |
| csr_wdata | input | XLEN | Write value |
| hw_pend_mext | input | 1 | Machine external interrupt source |
| hw_pend_mtim | input | 1 | Machine timer interrupt source |
| hw_pend_msw | input | 1 | Machine software interrupt source |
| hw_pend_sext | input | 1 | Supervisor external interrupt source |
| csr_rdata | output | XLEN | Read data of the selected view |
| mip_q | output | 12 | Pending register including hardware sources |
| mie_q | output | 12 | Enable register |
| mideleg_q | output | XLEN | Delegation mask |

## Verification
The hardest case to reach is the fold of a delegated machine interrupt into a supervisor bit of the pending view. Software can never set a machine pending bit, so only a hardware source can produce this case. The stimulus holds the machine timer source high across a clock edge. It then walks the delegation mask over settings that delegate the machine bit, the supervisor bit, both, or neither, and reads the supervisor view each time. The user enable bits are also reachable only through the supervisor enable view, so they are set with a user-only delegation mask and then checked to survive a machine-level enable write.

// File: rtl/irq_view_pkg.sv
package irq_view_pkg;

  localparam int IRQ_W = 12;

  localparam int B_MEXT = 11;
  localparam int B_SEXT = 9;
  localparam int B_UEXT = 8;
  localparam int B_MTIM = 7;
  localparam int B_STIM = 5;
  localparam int B_UTIM = 4;
  localparam int B_MSW  = 3;
  localparam int B_SSW  = 1;
  localparam int B_USW  = 0;

  // distance from a machine bit down to its supervisor counterpart
  localparam int FOLD_SHIFT = B_MEXT - B_SEXT;

  typedef logic [IRQ_W-1:0] irq_vec_t;

  typedef enum logic [2:0] {
    SEL_MPEND = 3'd0,
    SEL_MEN   = 3'd1,
    SEL_DELEG = 3'd2,
    SEL_SPEND = 3'd3,
    SEL_SEN   = 3'd4
  } irq_sel_e;

  localparam irq_vec_t M_MASK  = irq_vec_t'((1 << B_MEXT) | (1 << B_MTIM) | (1 << B_MSW));
  localparam irq_vec_t S_MASK  = irq_vec_t'((1 << B_SEXT) | (1 << B_STIM) | (1 << B_SSW));
  localparam irq_vec_t U_MASK  = irq_vec_t'((1 << B_UEXT) | (1 << B_UTIM) | (1 << B_USW));
  localparam irq_vec_t SU_MASK = S_MASK | U_MASK;
  localparam irq_vec_t SSW_BIT = irq_vec_t'(1 << B_SSW);

  function automatic irq_vec_t merge_bits(irq_vec_t old_v, irq_vec_t new_v, irq_vec_t mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic irq_vec_t legal_pend_wr(irq_vec_t old_v, irq_vec_t wr_v);
    return merge_bits(old_v, wr_v, S_MASK);
  endfunction

  function automatic irq_vec_t legal_en_wr(irq_vec_t old_v, irq_vec_t wr_v);
    return merge_bits(old_v, wr_v, M_MASK | S_MASK);
  endfunction

  function automatic irq_vec_t sview_pend(irq_vec_t pend, irq_vec_t dlg);
    irq_vec_t direct;
    irq_vec_t folded;
    direct = pend & dlg & SU_MASK;
    folded = (pend & dlg & M_MASK) >> FOLD_SHIFT;
    return direct | folded;
  endfunction

  function automatic irq_vec_t sview_en(irq_vec_t en, irq_vec_t dlg);
    return en & dlg & SU_MASK;
  endfunction

  function automatic irq_vec_t lift_spend(irq_vec_t old_v, irq_vec_t dlg, irq_vec_t wr_v);
    return merge_bits(old_v, wr_v & dlg, SSW_BIT);
  endfunction

  function automatic irq_vec_t lift_sen(irq_vec_t old_v, irq_vec_t dlg, irq_vec_t wr_v);
    return merge_bits(old_v, wr_v, dlg & SU_MASK);
  endfunction

endpackage

// File: rtl/irq_view_decode.sv
module irq_view_decode (
  input  logic       csr_we,
  input  logic [2:0] csr_sel,
  output logic       wr_mpend,
  output logic       wr_men,
  output logic       wr_deleg,
  output logic       wr_spend,
  output logic       wr_sen
);
  import irq_view_pkg::*;

  irq_sel_e sel_e;

  always_comb begin
    sel_e    = irq_sel_e'(csr_sel);
    wr_mpend = 1'b0;
    wr_men   = 1'b0;
    wr_deleg = 1'b0;
    wr_spend = 1'b0;
    wr_sen   = 1'b0;
    if (csr_we) begin
      case (sel_e)
        SEL_MPEND: wr_mpend = 1'b1;
        SEL_MEN:   wr_men   = 1'b1;
        SEL_DELEG: wr_deleg = 1'b1;
        SEL_SPEND: wr_spend = 1'b1;
        SEL_SEN:   wr_sen   = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/irq_view_regs.sv
module irq_view_regs #(
  parameter int XLEN = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_mpend,
  input  logic                          wr_men,
  input  logic                          wr_deleg,
  input  logic                          wr_spend,
  input  logic                          wr_sen,
  input  logic [XLEN-1:0]               wdata,
  input  irq_view_pkg::irq_vec_t        hw_vec,
  output irq_view_pkg::irq_vec_t        pend_q,
  output irq_view_pkg::irq_vec_t        en_q,
  output logic [XLEN-1:0]               dlg_q
);
  import irq_view_pkg::*;

  irq_vec_t sw_pend_q;
  irq_vec_t hw_pend_q;
  irq_vec_t wr_low;
  irq_vec_t dlg_low;

  assign wr_low  = wdata[IRQ_W-1:0];
  assign dlg_low = dlg_q[IRQ_W-1:0];

  // hardware sources: one register stage, level-following
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_pend_q <= '0;
    else        hw_pend_q <= hw_vec;
  end

  // software-held pending bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_pend_q <= '0;
    else if (wr_mpend) sw_pend_q <= legal_pend_wr(sw_pend_q, wr_low);
    else if (wr_spend) sw_pend_q <= lift_spend(sw_pend_q, dlg_low, wr_low);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_men) en_q <= legal_en_wr(en_q, wr_low);
    else if (wr_sen) en_q <= lift_sen(en_q, dlg_low, wr_low);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dlg_q <= '0;
    else if (wr_deleg) dlg_q <= wdata;
  end

  assign pend_q = sw_pend_q | hw_pend_q;

endmodule

// File: rtl/irq_view_rdmux.sv
module irq_view_rdmux #(
  parameter int XLEN = 64
) (
  input  logic [2:0]             csr_sel,
  input  irq_view_pkg::irq_vec_t pend_q,
  input  irq_view_pkg::irq_vec_t en_q,
  input  logic [XLEN-1:0]        dlg_q,
  output irq_view_pkg::irq_vec_t spend_view,
  output irq_view_pkg::irq_vec_t sen_view,
  output logic [XLEN-1:0]        rdata
);
  import irq_view_pkg::*;

  localparam int PAD_W = XLEN - IRQ_W;

  irq_vec_t dlg_low;
  irq_sel_e sel_e;

  assign dlg_low    = dlg_q[IRQ_W-1:0];
  assign spend_view = sview_pend(pend_q, dlg_low);
  assign sen_view   = sview_en(en_q, dlg_low);

  always_comb begin
    sel_e = irq_sel_e'(csr_sel);
    case (sel_e)
      SEL_MPEND: rdata = {{PAD_W{1'b0}}, pend_q};
      SEL_MEN:   rdata = {{PAD_W{1'b0}}, en_q};
      SEL_DELEG: rdata = dlg_q;
      SEL_SPEND: rdata = {{PAD_W{1'b0}}, spend_view};
      SEL_SEN:   rdata = {{PAD_W{1'b0}}, sen_view};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_csr_view.sv
module irq_csr_view #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            hw_pend_mext,
  input  logic            hw_pend_mtim,
  input  logic            hw_pend_msw,
  input  logic            hw_pend_sext,
  output logic [XLEN-1:0] csr_rdata,
  output logic [11:0]     mip_q,
  output logic [11:0]     mie_q,
  output logic [XLEN-1:0] mideleg_q
);
  import irq_view_pkg::*;

  logic     wr_mpend;
  logic     wr_men;
  logic     wr_deleg;
  logic     wr_spend;
  logic     wr_sen;
  irq_vec_t hw_vec;
  irq_vec_t spend_view;
  irq_vec_t sen_view;

  always_comb begin
    hw_vec         = '0;
    hw_vec[B_MEXT] = hw_pend_mext;
    hw_vec[B_MTIM] = hw_pend_mtim;
    hw_vec[B_MSW]  = hw_pend_msw;
    hw_vec[B_SEXT] = hw_pend_sext;
  end

  irq_view_decode u_dec (
    .csr_we   (csr_we),
    .csr_sel  (csr_sel),
    .wr_mpend (wr_mpend),
    .wr_men   (wr_men),
    .wr_deleg (wr_deleg),
    .wr_spend (wr_spend),
    .wr_sen   (wr_sen)
  );

  irq_view_regs #(.XLEN(XLEN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mpend (wr_mpend),
    .wr_men   (wr_men),
    .wr_deleg (wr_deleg),
    .wr_spend (wr_spend),
    .wr_sen   (wr_sen),
    .wdata    (csr_wdata),
    .hw_vec   (hw_vec),
    .pend_q   (mip_q),
    .en_q     (mie_q),
    .dlg_q    (mideleg_q)
  );

  irq_view_rdmux #(.XLEN(XLEN)) u_rd (
    .csr_sel    (csr_sel),
    .pend_q     (mip_q),
    .en_q       (mie_q),
    .dlg_q      (mideleg_q),
    .spend_view (spend_view),
    .sen_view   (sen_view),
    .rdata      (csr_rdata)
  );

endmodule

// File: rtl/irq_view_chk.sv
module irq_view_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_we,
  input logic [2:0]      csr_sel,
  input logic [XLEN-1:0] csr_wdata,
  input logic            hw_pend_mext,
  input logic            hw_pend_mtim,
  input logic            hw_pend_msw,
  input logic            hw_pend_sext,
  input logic [XLEN-1:0] csr_rdata,
  input logic [11:0]     mip_q,
  input logic [11:0]     mie_q,
  input logic [XLEN-1:0] mideleg_q,
  input logic            wr_mpend,
  input logic            wr_men,
  input logic            wr_deleg,
  input logic            wr_spend,
  input logic            wr_sen
);

  assert_pend_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_mpend) |->
      (mip_q[5] == $past(csr_wdata[5])) && (mip_q[1] == $past(csr_wdata[1])) &&
      ((mip_q & 12'h111) == 12'h000));

  assert_en_user_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_men) |-> (mie_q & 12'h111) == ($past(mie_q) & 12'h111));

  assert_deleg_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_deleg) |-> mideleg_q == $past(csr_wdata));

  assert_sen_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel == 3'd4) |->
      (csr_rdata[XLEN-1:12] == '0) && !csr_rdata[11] && !csr_rdata[10] &&
      !csr_rdata[7] && !csr_rdata[6] && !csr_rdata[3] && !csr_rdata[2]);

  assert_spend_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_spend) |->
      (mip_q[1] == ($past(csr_wdata[1]) & $past(mideleg_q[1]))) &&
      (mip_q[5] == $past(mip_q[5])));

  assert_sen_undeleg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_sen) |->
      ((mie_q ^ $past(mie_q)) & ~$past(mideleg_q[11:0])) == 12'h000);

  assert_hw_mext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(hw_pend_mext) |-> mip_q[11]);

  assert_hw_mtim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(hw_pend_mtim) |-> mip_q[7]);

  assert_hw_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(hw_pend_msw) |-> !mip_q[3]);

  assert_hw_sext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(hw_pend_sext) |-> mip_q[9]);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |-> (mip_q == 12'h000) && (mie_q == 12'h000) && (mideleg_q == '0));

  assert_bad_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(csr_we) && ($past(csr_sel) > 3'd4) |->
      (mie_q == $past(mie_q)) && (mideleg_q == $past(mideleg_q)) &&
      !$past(wr_mpend || wr_men || wr_deleg || wr_spend || wr_sen));

endmodule

bind irq_csr_view irq_view_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/irq_csr_view_tb.sv
module irq_csr_view_tb;

  localparam int XLEN = 64;
  localparam logic [63:0] ONES = '1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            csr_we = 1'b0;
  logic [2:0]      csr_sel = 3'd0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic            hw_pend_mext = 1'b0;
  logic            hw_pend_mtim = 1'b0;
  logic            hw_pend_msw = 1'b0;
  logic            hw_pend_sext = 1'b0;
  logic [XLEN-1:0] csr_rdata;
  logic [11:0]     mip_q;
  logic [11:0]     mie_q;
  logic [XLEN-1:0] mideleg_q;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_csr_view #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .hw_pend_mext(hw_pend_mext), .hw_pend_mtim(hw_pend_mtim),
    .hw_pend_msw(hw_pend_msw), .hw_pend_sext(hw_pend_sext), .csr_rdata(csr_rdata),
    .mip_q(mip_q), .mie_q(mie_q), .mideleg_q(mideleg_q)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write lands at the posedge between the two negedges
  task automatic wr(input logic [2:0] s, input logic [63:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = s; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [2:0] s, input logic [63:0] exp);
    csr_sel = s;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 5; s++) expect_rd("R9 view after reset", 3'(s), 64'h0);
    chk("R9 mip_q", {52'h0, mip_q}, 64'h0);
    chk("R9 mie_q", {52'h0, mie_q}, 64'h0);
    chk("R9 mideleg_q", mideleg_q, 64'h0);
  endtask

  task automatic t_pend_write;
    wr(3'd0, ONES);
    expect_rd("R1 pending all-ones write", 3'd0, 64'h222);
    wr(3'd0, 64'h020);
    expect_rd("R1 pending single S bit", 3'd0, 64'h020);
    wr(3'd0, 64'h0);
    expect_rd("R1 pending cleared", 3'd0, 64'h0);
  endtask

  task automatic t_en_write;
    wr(3'd1, ONES);
    expect_rd("R2 enable all-ones write", 3'd1, 64'hAAA);
    wr(3'd2, 64'h111);
    wr(3'd4, ONES);
    expect_rd("R7 user enables via S view", 3'd1, 64'hBBB);
    wr(3'd1, 64'h0);
    expect_rd("R2 user enables survive M write", 3'd1, 64'h111);
    wr(3'd4, 64'h0);
    expect_rd("R7 user enables cleared", 3'd1, 64'h0);
  endtask

  task automatic t_deleg;
    wr(3'd2, 64'hA5A5_0000_F00D_1234);
    expect_rd("R3 delegation readback", 3'd2, 64'hA5A5_0000_F00D_1234);
    chk("R3 mideleg_q port", mideleg_q, 64'hA5A5_0000_F00D_1234);
  endtask

  task automatic t_sen;
    wr(3'd2, 64'h222);
    wr(3'd1, ONES);
    expect_rd("R5 S enable view S-delegated", 3'd4, 64'h222);
    wr(3'd2, 64'hFFF);
    expect_rd("R5 machine positions read zero", 3'd4, 64'h222);
    wr(3'd2, 64'h020);
    expect_rd("R5 single delegated bit", 3'd4, 64'h020);
    wr(3'd4, 64'h0);
    expect_rd("R7 only delegated bit cleared", 3'd1, 64'hA8A);
    wr(3'd2, 64'h001);
    wr(3'd4, ONES);
    expect_rd("R7 only user sw bit set", 3'd1, 64'hA8B);
    expect_rd("R5 view with user delegation", 3'd4, 64'h001);
  endtask

  task automatic t_spend;
    wr(3'd0, 64'h222);
    wr(3'd2, 64'h0);
    expect_rd("R4 nothing delegated", 3'd3, 64'h0);
    wr(3'd2, 64'h002);
    expect_rd("R4 S sw delegated", 3'd3, 64'h002);
    wr(3'd2, 64'h220);
    expect_rd("R4 S ext and tim delegated", 3'd3, 64'h220);
    hw_pend_mtim = 1'b1;
    wr(3'd2, 64'h080);
    chk("R8 timer source in pending", {52'h0, mip_q}, 64'h2A2);
    expect_rd("R4 machine timer folds to bit 5", 3'd3, 64'h020);
    wr(3'd2, 64'h0);
    wr(3'd3, ONES);
    expect_rd("R6 undelegated S write clears bit 1", 3'd0, 64'h2A0);
    wr(3'd2, 64'h002);
    wr(3'd3, 64'h002);
    expect_rd("R6 delegated S write sets bit 1", 3'd0, 64'h2A2);
    wr(3'd0, 64'h0);
    expect_rd("R8 software cannot clear timer", 3'd0, 64'h080);
    wr(3'd2, 64'hFFF);
    wr(3'd3, ONES);
    expect_rd("R6 only bit 1 written", 3'd0, 64'h082);
    expect_rd("R4 fold plus direct", 3'd3, 64'h022);
    hw_pend_mtim = 1'b0;
  endtask

  task automatic t_hw;
    wr(3'd0, 64'h0);
    hw_pend_mext = 1'b1; hw_pend_msw = 1'b1; hw_pend_sext = 1'b1;
    @(negedge clk);
    expect_rd("R8 sources visible after edge", 3'd0, 64'hA08);
    wr(3'd0, 64'h0);
    expect_rd("R8 software write cannot clear", 3'd0, 64'hA08);
    wr(3'd0, ONES);
    expect_rd("R8 software adds only S bits", 3'd0, 64'hA2A);
    hw_pend_mext = 1'b0; hw_pend_msw = 1'b0; hw_pend_sext = 1'b0;
    @(negedge clk);
    expect_rd("R8 sources released", 3'd0, 64'h222);
    wr(3'd0, 64'h0);
  endtask

  task automatic t_badsel;
    logic [63:0] en_before;
    logic [63:0] dl_before;
    csr_sel = 3'd1; #1; en_before = csr_rdata;
    csr_sel = 3'd2; #1; dl_before = csr_rdata;
    wr(3'd5, ONES);
    wr(3'd7, 64'h0);
    wr(3'd6, ONES);
    expect_rd("R10 enable untouched", 3'd1, en_before);
    expect_rd("R10 delegation untouched", 3'd2, dl_before);
    expect_rd("R10 pending untouched", 3'd0, 64'h0);
    for (int s = 5; s < 8; s++) expect_rd("R10 unused code reads zero", 3'(s), 64'h0);
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_pend_write();
    t_en_write();
    t_deleg();
    t_sen();
    t_spend();
    t_hw();
    t_badsel();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule